// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date in eight byte-wide registers held in packed binary-coded decimal. A free-running pulse `tick_i` drives it. An internal phase counter divides that pulse by `TICKS_PER_SEC`. Each time the divider completes, the seconds field advances by one, and carries ripple through minutes, hours, day of week, date, month and year.

The hours field works in either a 12-hour or a 24-hour mode, chosen by its top bit. A run/stop bit in the seconds byte freezes the whole counter, and a lock bit in the control byte protects the time and date bytes from host writes. A host reads any register through a combinational read port and loads any register through a single-cycle write port. A load takes effect at the next clock edge.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, reading addresses 0..7 returns 0x80, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 and 0x00. The seconds byte comes up with its stop bit set, so nothing counts until the host clears it.
- R2: The address map is fixed: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year, 7 control. Reads are combinational. A written byte is stored ANDed with a per-address mask: 0xFF, 0x7F, 0xBF, 0x3F, 0x1F, 0x07, 0xFF and 0x80 for addresses 0 to 7.
- R3: While running, every `TICKS_PER_SEC` accepted ticks advance the seconds by one (default 4). The seconds change on the clock edge that samples the last tick. Seconds and minutes count 00..59 in BCD, and each wraps to 00 with a carry into the next field, including after the host loads 59.
- R4: Seconds bit 7 is a stop bit. While it is 1, ticks are ignored, the phase counter is frozen and no register advances. Writing seconds with bit 7 at 0 restarts counting.
- R5: With hours bit 7 at 0 (24-hour mode), hours count 00..23, using bit 5 as the tens-of-hours bit for 20..23. 23 wraps to 00 and carries into the day.
- R6: With hours bit 7 at 1 (12-hour mode), bits 4:0 count 12, 01, ..., 11 and bit 5 is the PM flag (1 = PM). The PM flag toggles on the step from 11 to 12. The step from 11 PM to 12 AM carries into the day.
- R7: A day carry advances the day of week 1..7 (7 wraps to 1). It also advances the date, which wraps to 01 after the month's last day and carries into the month. The month wraps from 12 to 01 and carries into the year, and the year wraps from 99 to 00.
- R8: Month lengths are 31 days for months 01, 03, 05, 07, 08, 10 and 12, and 30 days for 04, 06, 09 and 11. February has 29 days when the year value is divisible by four and 28 days otherwise.
- R9: Control bit 7 is a lock. While it is 1, writes to addresses 0..6 are ignored and counting continues. Address 7 is always writable, and its bits 6:0 read as 0.
- R10: An accepted write has priority over a tick in the same cycle: that tick is dropped, leaving the phase and all other registers unchanged. An accepted write to seconds also clears the phase, so the next second needs a full `TICKS_PER_SEC` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sub-second tick pulse, one clock wide |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Host write register address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` |

## Verification
A host write and the tick that completes a second can arrive in the same clock cycle. The directed part of the bench provokes this by bringing the phase to its last step and then pulsing `tick_i` together with a write to the minutes. It expects the seconds to stay put, and it expects the next lone tick to roll the second, proving that the phase was neither advanced nor reset. The random part mixes writes, locked writes, stop-bit loads and ticks in the same cycles. Every read-back is judged against a binary-arithmetic calendar model kept in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_DATE  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_MONTH = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_DOW   = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_YEAR  = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd7;

    typedef struct packed {
        logic [REG_W-1:0] sec;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] hour;
        logic [REG_W-1:0] date;
        logic [REG_W-1:0] month;
        logic [REG_W-1:0] dow;
        logic [REG_W-1:0] year;
        logic [REG_W-1:0] ctrl;
    } rtc_regs_t;

    // Add one to a two-digit BCD byte (caller handles the wrap).
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last valid date of a month, in BCD. The leap test works on the two
    // BCD digits: a value is a multiple of four when an even tens digit
    // meets 0/4/8 or an odd tens digit meets 2/6.
    function automatic logic [7:0] month_last(input logic [7:0] month,
                                              input logic [7:0] year);
        logic leap;
        leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                       : (year[3:0] == 4'd0 || year[3:0] == 4'd4 ||
                          year[3:0] == 4'd8);
        case (month)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Bits that exist in each register; the rest read as zero.
    function automatic logic [7:0] wr_mask(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_SEC:   return 8'hFF;
            ADDR_MIN:   return 8'h7F;
            ADDR_HOUR:  return 8'hBF;
            ADDR_DATE:  return 8'h3F;
            ADDR_MONTH: return 8'h1F;
            ADDR_DOW:   return 8'h07;
            ADDR_YEAR:  return 8'hFF;
            default:    return 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int unsigned TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic clear_i,
    output logic sec_step_o
);
    localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d    = phase_q;
        sec_step_o = 1'b0;
        if (clear_i) begin
            phase_d = '0;
        end else if (!hold_i && tick_i) begin
            if (phase_q == LAST) begin
                phase_d    = '0;
                sec_step_o = 1'b1;
            end else begin
                phase_d = phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
    import rtc_pkg::*;
(
    input  logic       step_i,
    input  logic [7:0] sec_i,
    input  logic [7:0] min_i,
    input  logic [7:0] hour_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       day_o
);
    logic [7:0] sec_inc, min_inc, hr12_inc, hr24_inc;
    logic       min_cy, hour_cy, pm_n;

    assign sec_inc  = bcd_step(sec_i);
    assign min_inc  = bcd_step(min_i);
    assign hr12_inc = bcd_step({3'b000, hour_i[4:0]});
    assign hr24_inc = bcd_step({1'b0, hour_i[6:0]});

    always_comb begin
        sec_o   = sec_i;
        min_o   = min_i;
        hour_o  = hour_i;
        day_o   = 1'b0;
        min_cy  = 1'b0;
        hour_cy = 1'b0;
        pm_n    = hour_i[5];

        if (step_i) begin
            if (sec_i == 8'h59) begin
                sec_o  = 8'h00;
                min_cy = 1'b1;
            end else begin
                sec_o = sec_inc;
            end
        end

        if (min_cy) begin
            if (min_i == 8'h59) begin
                min_o   = 8'h00;
                hour_cy = 1'b1;
            end else begin
                min_o = min_inc;
            end
        end

        if (hour_cy) begin
            if (hour_i[7]) begin
                if (hour_i[4:0] == 5'h12) begin
                    hour_o = {1'b1, 1'b0, pm_n, 5'h01};
                end else if (hour_i[4:0] == 5'h11) begin
                    day_o  = hour_i[5];
                    pm_n   = ~hour_i[5];
                    hour_o = {1'b1, 1'b0, pm_n, 5'h12};
                end else begin
                    hour_o = hr12_inc | {1'b1, 1'b0, pm_n, 5'h00};
                end
            end else begin
                if (hour_i[6:0] == 7'h23) begin
                    hour_o = 8'h00;
                    day_o  = 1'b1;
                end else begin
                    hour_o = hr24_inc;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_date_adv.sv
module rtc_date_adv
    import rtc_pkg::*;
(
    input  logic       day_i,
    input  logic [7:0] date_i,
    input  logic [7:0] month_i,
    input  logic [7:0] dow_i,
    input  logic [7:0] year_i,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] dow_o,
    output logic [7:0] year_o
);
    logic [7:0] last_day;
    logic [7:0] date_inc, month_inc, dow_inc, year_inc;
    logic       mon_cy, year_cy;

    assign last_day  = month_last(month_i, year_i);
    assign date_inc  = bcd_step(date_i);
    assign month_inc = bcd_step(month_i);
    assign dow_inc   = bcd_step(dow_i);
    assign year_inc  = bcd_step(year_i);

    always_comb begin
        date_o  = date_i;
        month_o = month_i;
        dow_o   = dow_i;
        year_o  = year_i;
        mon_cy  = 1'b0;
        year_cy = 1'b0;

        if (day_i) begin
            dow_o = (dow_i == 8'h07) ? 8'h01 : dow_inc;
            if (date_i == last_day) begin
                date_o = 8'h01;
                mon_cy = 1'b1;
            end else begin
                date_o = date_inc;
            end
        end

        if (mon_cy) begin
            if (month_i == 8'h12) begin
                month_o = 8'h01;
                year_cy = 1'b1;
            end else begin
                month_o = month_inc;
            end
        end

        if (year_cy) begin
            year_o = (year_i == 8'h99) ? 8'h00 : year_inc;
        end
    end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o
);
    localparam rtc_regs_t RESET_VAL = '{
        sec: 8'h80, min: 8'h00, hour: 8'h00, date: 8'h01,
        month: 8'h01, dow: 8'h01, year: 8'h00, ctrl: 8'h00
    };

    rtc_regs_t        state_d, state_q;
    logic             wr_ok, hold, clear_phase, sec_step, day_cy;
    logic [REG_W-1:0] wdata;
    logic [REG_W-1:0] sec_n, min_n, hour_n, date_n, month_n, dow_n, year_n;

    // Lock bit blocks every address except the control byte itself.
    assign wr_ok       = wr_en_i && (!state_q.ctrl[7] || wr_addr_i == ADDR_CTRL);
    assign hold        = wr_ok || state_q.sec[7];
    assign clear_phase = wr_ok && (wr_addr_i == ADDR_SEC);
    assign wdata       = wr_data_i & wr_mask(wr_addr_i);

    rtc_tick_div #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .hold_i     (hold),
        .clear_i    (clear_phase),
        .sec_step_o (sec_step)
    );

    rtc_time_adv i_time (
        .step_i (sec_step),
        .sec_i  (state_q.sec),
        .min_i  (state_q.min),
        .hour_i (state_q.hour),
        .sec_o  (sec_n),
        .min_o  (min_n),
        .hour_o (hour_n),
        .day_o  (day_cy)
    );

    rtc_date_adv i_date (
        .day_i   (day_cy),
        .date_i  (state_q.date),
        .month_i (state_q.month),
        .dow_i   (state_q.dow),
        .year_i  (state_q.year),
        .date_o  (date_n),
        .month_o (month_n),
        .dow_o   (dow_n),
        .year_o  (year_n)
    );

    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            case (wr_addr_i)
                ADDR_SEC:   state_d.sec   = wdata;
                ADDR_MIN:   state_d.min   = wdata;
                ADDR_HOUR:  state_d.hour  = wdata;
                ADDR_DATE:  state_d.date  = wdata;
                ADDR_MONTH: state_d.month = wdata;
                ADDR_DOW:   state_d.dow   = wdata;
                ADDR_YEAR:  state_d.year  = wdata;
                default:    state_d.ctrl  = wdata;
            endcase
        end else begin
            state_d.sec   = sec_n;
            state_d.min   = min_n;
            state_d.hour  = hour_n;
            state_d.date  = date_n;
            state_d.month = month_n;
            state_d.dow   = dow_n;
            state_d.year  = year_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (rd_addr_i)
            ADDR_SEC:   rd_data_o = state_q.sec;
            ADDR_MIN:   rd_data_o = state_q.min;
            ADDR_HOUR:  rd_data_o = state_q.hour;
            ADDR_DATE:  rd_data_o = state_q.date;
            ADDR_MONTH: rd_data_o = state_q.month;
            ADDR_DOW:   rd_data_o = state_q.dow;
            ADDR_YEAR:  rd_data_o = state_q.year;
            default:    rd_data_o = state_q.ctrl;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [REG_W-1:0]  rd_data_o,
    input rtc_regs_t         regs
);

    // R4
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.sec[7] && !wr_en_i) |=> $stable(regs));

    // R9
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl[7] && wr_en_i && wr_addr_i != ADDR_CTRL && !tick_i) |=> $stable(regs));

    // R9
    ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == ADDR_CTRL) |-> (rd_data_o[6:0] == 7'd0));

    // R10
    ctrl_write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_CTRL) |=>
            ($stable(regs.sec) && $stable(regs.min) && $stable(regs.hour) &&
             $stable(regs.date) && $stable(regs.month) && $stable(regs.dow) &&
             $stable(regs.year)));

    // R6
    pm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && regs.hour[7] && regs.hour[4:0] == 5'h11) |=>
            (regs.hour[4:0] == 5'h11 ||
             (regs.hour[4:0] == 5'h12 && regs.hour[5] != $past(regs.hour[5]))));

endmodule

bind rtc_bcd_core rtc_bcd_core_chk i_rtc_bcd_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .regs      (state_q)
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;

    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = 3'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic [2:0] rd_addr_i = 3'd0;
    logic [7:0] rd_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] m [8];
    int         m_phase;

    always #10 clk = ~clk;

    rtc_bcd_core #(.TICKS_PER_SEC(TPS)) i_rtc_bcd_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    // ---------------- reference model (binary arithmetic) ----------------
    function automatic int bcd2bin(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] bin2bcd(input int b);
        return {4'(b / 10), 4'(b % 10)};
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mask_of(input int a);
        case (a)
            0: return 8'hFF; 1: return 8'h7F; 2: return 8'hBF; 3: return 8'h3F;
            4: return 8'h1F; 5: return 8'h07; 6: return 8'hFF; default: return 8'h80;
        endcase
    endfunction

    task automatic model_day();
        int d, mo, y, w;
        d = bcd2bin(m[3]); mo = bcd2bin(m[4]); w = bcd2bin(m[5]); y = bcd2bin(m[6]);
        w = (w == 7) ? 1 : w + 1;
        if (d == days_in(mo, y)) begin
            d = 1;
            if (mo == 12) begin mo = 1; y = (y + 1) % 100; end
            else mo = mo + 1;
        end else d = d + 1;
        m[3] = bin2bcd(d); m[4] = bin2bcd(mo); m[5] = bin2bcd(w); m[6] = bin2bcd(y);
    endtask

    task automatic model_hour();
        int h;
        bit pm, carry;
        carry = 1'b0;
        if (m[2][7]) begin
            h  = bcd2bin({3'b000, m[2][4:0]});
            pm = m[2][5];
            if (h == 11) begin h = 12; carry = pm; pm = ~pm; end
            else if (h == 12) h = 1;
            else h = h + 1;
            m[2] = 8'h80 | (pm ? 8'h20 : 8'h00) | bin2bcd(h);
        end else begin
            h = bcd2bin({2'b00, m[2][5:0]});
            if (h == 23) begin h = 0; carry = 1'b1; end
            else h = h + 1;
            m[2] = bin2bcd(h);
        end
        if (carry) model_day();
    endtask

    task automatic model_second();
        int s, mi;
        s = bcd2bin(m[0]);
        if (s == 59) begin
            m[0] = 8'h00;
            mi = bcd2bin(m[1]);
            if (mi == 59) begin m[1] = 8'h00; model_hour(); end
            else m[1] = bin2bcd(mi + 1);
        end else m[0] = bin2bcd(s + 1);
    endtask

    task automatic model_edge(input bit tk, input bit wr, input int a, input logic [7:0] d);
        bit ok;
        ok = wr && (!m[7][7] || a == 7);
        if (ok) begin
            m[a] = d & mask_of(a);
            if (a == 0) m_phase = 0;
        end else if (tk && !m[0][7]) begin
            m_phase = m_phase + 1;
            if (m_phase == TPS) begin m_phase = 0; model_second(); end
        end
    endtask

    // ---------------- stimulus and checking ----------------
    task automatic drive(input bit tk, input bit wr, input int a, input logic [7:0] d);
        @(negedge clk);
        tick_i = tk; wr_en_i = wr; wr_addr_i = 3'(a); wr_data_i = d;
        @(posedge clk);
        model_edge(tk, wr, a, d);
    endtask

    task automatic put(input int a, input logic [7:0] d);
        drive(1'b0, 1'b1, a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 0, 8'h00);
    endtask

    task automatic peek(input int a, input string tag);
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0; rd_addr_i = 3'(a);
        #1;
        n_checks++;
        if (rd_data_o !== m[a]) begin
            n_fail++;
            $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rd_data_o, m[a]);
        end
    endtask

    task automatic peek_all(input string tag);
        for (int a = 0; a < 8; a++) peek(a, tag);
    endtask

    task automatic set_time(input logic [7:0] hr, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        put(2, hr); put(3, dt); put(4, mo); put(6, yr);
        put(1, 8'h59); put(0, 8'h59);
    endtask

    function automatic logic [7:0] rand_val(input int a);
        int r;
        r = int'($urandom % 1000);
        case (a)
            0: return bin2bcd(r % 60) | ((r % 11 == 0) ? 8'h80 : 8'h00);
            1: return bin2bcd(r % 60);
            2: if (r % 2 == 0) return 8'h80 | ((r % 4 == 0) ? 8'h20 : 8'h00) | bin2bcd(1 + r % 12);
               else return bin2bcd(r % 24);
            3: return bin2bcd(1 + r % 28);
            4: return bin2bcd(1 + r % 12);
            5: return bin2bcd(1 + r % 7);
            6: return bin2bcd(r % 100);
            default: return (r % 5 == 0) ? 8'h80 : 8'h00;
        endcase
    endfunction

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd5150));
        m[0] = 8'h80; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h00;
        m_phase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        peek_all("R1");
        // R4 stopped after reset: ticks change nothing
        ticks(10);
        peek_all("R4");

        // R2 masks: all-ones into every register (seconds first, stop bit set)
        for (int a = 0; a < 8; a++) put(a, 8'hFF);
        peek_all("R2");
        put(7, 8'h00);
        put(2, 8'h10); put(3, 8'h15); put(4, 8'h06); put(5, 8'h03); put(6, 8'h21);
        put(1, 8'h00);

        // R3 seconds cadence and carry from a loaded 59
        put(0, 8'h58);
        ticks(TPS - 1); peek(0, "R3");
        ticks(1);       peek(0, "R3");
        ticks(TPS);     peek(0, "R3"); peek(1, "R3");

        // R4 stop mid-run, then resume
        put(0, 8'h95); ticks(3 * TPS); peek(0, "R4"); peek(1, "R4");
        put(0, 8'h15); ticks(TPS); peek(0, "R4");

        // R10 completing tick collides with a minute write
        put(0, 8'h59);
        ticks(TPS - 1);
        drive(1'b1, 1'b1, 1, 8'h10);
        peek(0, "R10"); peek(1, "R10");
        ticks(1); peek(0, "R10"); peek(1, "R10");
        // R10 seconds write clears the phase
        ticks(TPS - 1); put(0, 8'h30); ticks(1); peek(0, "R10");
        ticks(TPS - 1); peek(0, "R10");

        // R6 12-hour mode: 11 AM -> 12 PM, 11 PM -> 12 AM with day carry, 12 -> 1
        set_time(8'h91, 8'h15, 8'h06, 8'h21); ticks(TPS); peek(2, "R6"); peek(3, "R6");
        set_time(8'hB1, 8'h15, 8'h06, 8'h21); ticks(TPS); peek(2, "R6"); peek(3, "R6");
        set_time(8'h92, 8'h15, 8'h06, 8'h21); ticks(TPS); peek(2, "R6");
        set_time(8'h89, 8'h15, 8'h06, 8'h21); ticks(TPS); peek(2, "R6");

        // R5 24-hour mode tens digits and wrap
        set_time(8'h09, 8'h15, 8'h06, 8'h21); ticks(TPS); peek(2, "R5");
        set_time(8'h19, 8'h15, 8'h06, 8'h21); ticks(TPS); peek(2, "R5");
        // R7 full wrap: 23:59:59 Dec 31, year 99, day 7
        put(5, 8'h07);
        set_time(8'h23, 8'h31, 8'h12, 8'h99); ticks(TPS); peek_all("R7");

        // R8 month lengths and leap years
        set_time(8'h23, 8'h28, 8'h02, 8'h24); ticks(TPS); peek(3, "R8"); peek(4, "R8");
        set_time(8'h23, 8'h29, 8'h02, 8'h24); ticks(TPS); peek(3, "R8"); peek(4, "R8");
        set_time(8'h23, 8'h28, 8'h02, 8'h23); ticks(TPS); peek(3, "R8"); peek(4, "R8");
        set_time(8'h23, 8'h28, 8'h02, 8'h12); ticks(TPS); peek(3, "R8");
        set_time(8'h23, 8'h28, 8'h02, 8'h10); ticks(TPS); peek(3, "R8");
        set_time(8'h23, 8'h30, 8'h04, 8'h10); ticks(TPS); peek(3, "R8"); peek(4, "R8");
        set_time(8'h23, 8'h30, 8'h01, 8'h10); ticks(TPS); peek(3, "R8");

        // R9 lock: writes ignored, counting continues, control readback
        put(1, 8'h20); put(0, 8'h10);
        put(7, 8'hFF); peek(7, "R9");
        put(1, 8'h33); put(0, 8'h45); peek(1, "R9"); peek(0, "R9");
        ticks(TPS); peek(0, "R9");
        put(7, 8'h00); put(1, 8'h33); peek(1, "R9"); peek(7, "R9");

        // Random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            int r, a;
            r = int'($urandom % 100);
            a = int'($urandom % 8);
            if (r < 60)      drive(1'b1, 1'b0, 0, 8'h00);
            else if (r < 72) drive(1'b0, 1'b1, a, rand_val(a));
            else if (r < 80) drive(1'b1, 1'b1, a, rand_val(a));
            else if (r < 85) begin put(1, 8'h59); put(0, 8'h59); end
            else             drive(1'b0, 1'b0, 0, 8'h00);
            peek(int'($urandom % 8), "RND");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule